// File: doc/BRIEF.md
# Banked Lane Scratchpad

This block is the on-chip scratch storage used by one group of sixteen lanes. It holds 16 KiB split across sixteen independent single-ported banks. Each bank holds 256 words of 32 bits. A request carries, for each lane, an enable, a write flag, a 12-bit word address and 32 bits of write data. The block accepts the group and latches it. It then serves the lanes over one or more cycles. In each cycle it makes at most one word access per bank. It pulses a completion strobe once every enabled lane has been served.

Lanes that fall in different banks are served in the same cycle. Lanes that touch different words of the same bank are spread over later cycles: the lowest-numbered pending lane picks the word for the bank in each cycle. All lanes that name that same word are served together. Readers of that word share one fetch. Among writers of that word, the highest-numbered lane's data is kept. There is no cache. Every access reaches the banks directly, so data written by one lane can be read by any lane in a later group.

Top module: `spm_scratchpad`

## Requirements
- R1: The bank of a word address is its low 4 bits (bits 3:0). The row inside the bank is bits 11:4. So 16 consecutive word addresses use 16 different banks and are served in a single round.
- R2: A group whose enabled lanes all fall in different banks, or share words, is accepted in the cycle it is presented with no group in flight (cycle t). `done` is then high in cycle t+2.
- R3: When the enabled lanes of a group name k different words in one bank (k being the largest such count over all banks), the group takes k rounds. `done` is high in cycle t+1+k.
- R4: Lanes that read the same word in one group are all served in the same round, and each returns that word's value.
- R5: When several lanes write the same word in one group, the word afterwards holds the data of the highest-numbered of those lanes.
- R6: When lanes read a word that other lanes of the same group write, the readers return the value the word held before that group.
- R7: A word written by one group is returned unchanged to any lane that reads it in a later group.
- R8: While a group is in flight, the lane inputs are ignored: a new request presented then is neither stored nor written, and changing the inputs does not alter the group in flight.
- R9: `done` is high for exactly one cycle. A new group presented in the `done` cycle is accepted there.
- R10: After reset, `done` is low and every lane's read data is zero.
- R11: A lane that is not enabled neither reads nor writes. A lane that does not read in a group keeps its previous read data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| lane_en | input | 16 | Per-lane request enable; any set bit while idle starts a group |
| lane_we | input | 16 | Per-lane write flag (1 = write, 0 = read) |
| lane_addr | input | 192 | Per-lane 12-bit word address, lane n in bits 12n+11:12n |
| lane_wdata | input | 512 | Per-lane 32-bit write data, lane n in bits 32n+31:32n |
| lane_rdata | output | 512 | Per-lane 32-bit read result, lane n in bits 32n+31:32n |
| done | output | 1 | One-cycle strobe: every enabled lane of the group has been served |

## Verification
In a single bank round, one word can be both fetched for broadcast to several readers and overwritten by several writers. The read and the write then land on the same clock edge. The bench provokes this with one group in which two lanes read a word while two other lanes, one below and one above them in lane order, write it. It judges the outcome three ways. The group must finish in one round. Both readers must return the word's earlier contents. A later read must return the higher lane's data.

// File: rtl/spm_pkg.sv
package spm_pkg;
  // Default geometry: 16 lanes, 16 banks of 256 x 32-bit words.
  parameter int unsigned DEF_LANES = 16;
  parameter int unsigned DEF_BANKS = 16;
  parameter int unsigned DEF_ROWS  = 256;
  parameter int unsigned DEF_DW    = 32;
endpackage

// File: rtl/spm_bank_arb.sv
// Per-bank picker: selects the word of the lowest pending lane in this bank
// and marks every pending lane that names the same word.
module spm_bank_arb #(
  parameter int unsigned LANES   = 16,
  parameter int unsigned BANK_W  = 4,
  parameter int unsigned ROW_W   = 8,
  parameter int unsigned DW      = 32,
  parameter int unsigned BANK_ID = 0,
  localparam int unsigned AW     = BANK_W + ROW_W
) (
  input  logic [LANES-1:0]    pend,
  input  logic [LANES-1:0]    we,
  input  logic [LANES*AW-1:0] addr,
  input  logic [LANES*DW-1:0] wdata,
  output logic [LANES-1:0]    hit,
  output logic [ROW_W-1:0]    row,
  output logic                wr_en,
  output logic [DW-1:0]       wr_data
);
  localparam logic [BANK_W-1:0] SEL = BANK_W'(BANK_ID);

  logic [LANES-1:0] in_bank;
  logic [AW-1:0]    win_addr;
  logic             found;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      in_bank[l] = pend[l] && (addr[l*AW +: BANK_W] == SEL);
    end
  end

  // lowest-numbered pending lane chooses the word
  always_comb begin
    found    = 1'b0;
    win_addr = '0;
    for (int l = 0; l < LANES; l++) begin
      if (!found && in_bank[l]) begin
        found    = 1'b1;
        win_addr = addr[l*AW +: AW];
      end
    end
  end

  // merge same-word lanes; ascending scan leaves the highest writer's data
  always_comb begin
    wr_en   = 1'b0;
    wr_data = '0;
    for (int l = 0; l < LANES; l++) begin
      hit[l] = in_bank[l] && (addr[l*AW +: AW] == win_addr);
      if (hit[l] && we[l]) begin
        wr_en   = 1'b1;
        wr_data = wdata[l*DW +: DW];
      end
    end
  end

  assign row = win_addr[AW-1:BANK_W];
endmodule

// File: rtl/spm_bank_store.sv
// One single-ported bank: one row per cycle, read of the addressed row and
// optional write of the same row on the clock edge.
module spm_bank_store #(
  parameter int unsigned ROWS  = 256,
  parameter int unsigned DW    = 32,
  localparam int unsigned ROW_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [ROW_W-1:0] row,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    rd_data
);
  logic [DW-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[row] <= wr_data;
    end
  end

  assign rd_data = mem[row];
endmodule

// File: rtl/spm_scratchpad.sv
module spm_scratchpad #(
  parameter int unsigned LANES  = spm_pkg::DEF_LANES,
  parameter int unsigned BANKS  = spm_pkg::DEF_BANKS,
  parameter int unsigned ROWS   = spm_pkg::DEF_ROWS,
  parameter int unsigned DW     = spm_pkg::DEF_DW,
  localparam int unsigned BANK_W = $clog2(BANKS),
  localparam int unsigned ROW_W  = $clog2(ROWS),
  localparam int unsigned AW     = BANK_W + ROW_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LANES-1:0]    lane_en,
  input  logic [LANES-1:0]    lane_we,
  input  logic [LANES*AW-1:0] lane_addr,
  input  logic [LANES*DW-1:0] lane_wdata,
  output logic [LANES*DW-1:0] lane_rdata,
  output logic                done
);
  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  logic                busy_q, busy_d, done_q, done_d;
  logic [LANES-1:0]    pend_q, pend_d, we_q, served, pend_left;
  logic [LANES*AW-1:0] addr_q;
  logic [LANES*DW-1:0] wdata_q, rd_q, rd_d;
  logic                accept, lat_en, rd_en;

  logic [LANES-1:0] hit_b   [BANKS];
  logic [ROW_W-1:0] row_b   [BANKS];
  logic             wen_b   [BANKS];
  logic [DW-1:0]    wd_b    [BANKS];
  logic [DW-1:0]    rd_b    [BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    spm_bank_arb #(
      .LANES(LANES), .BANK_W(BANK_W), .ROW_W(ROW_W), .DW(DW), .BANK_ID(b)
    ) u_arb (
      .pend(pend_q), .we(we_q), .addr(addr_q), .wdata(wdata_q),
      .hit(hit_b[b]), .row(row_b[b]), .wr_en(wen_b[b]), .wr_data(wd_b[b])
    );
    spm_bank_store #(.ROWS(ROWS), .DW(DW)) u_store (
      .clk(clk), .wr_en(wen_b[b]), .row(row_b[b]),
      .wr_data(wd_b[b]), .rd_data(rd_b[b])
    );
  end

  always_comb begin
    served = '0;
    for (int b = 0; b < BANKS; b++) begin
      served = served | hit_b[b];
    end
  end

  assign pend_left = pend_q & ~served;
  assign accept    = !busy_q && (|lane_en);
  assign lat_en    = accept;
  assign rd_en     = busy_q;

  // next state
  always_comb begin
    busy_d = busy_q;
    pend_d = pend_q;
    done_d = 1'b0;
    if (accept) begin
      busy_d = 1'b1;
      pend_d = lane_en;
    end else if (busy_q) begin
      pend_d = pend_left;
      busy_d = |pend_left;
      done_d = ~(|pend_left);
    end
  end

  // read capture: each served reader takes its bank's word
  always_comb begin
    rd_d = rd_q;
    for (int l = 0; l < LANES; l++) begin
      if (served[l] && !we_q[l]) begin
        rd_d[l*DW +: DW] = rd_b[addr_q[l*AW +: BANK_W]];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      pend_q  <= '0;
      we_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rd_q    <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      pend_q <= pend_d;
      if (lat_en) begin
        we_q    <= lane_we;
        addr_q  <= lane_addr;
        wdata_q <= lane_wdata;
      end
      if (rd_en) begin
        rd_q <= rd_d;
      end
    end
  end

  assign lane_rdata = rd_q;
  assign done       = done_q;

  // R3: each round serves only pending lanes and always makes progress
  assert_serve_pending_R3: assert property (@(posedge clk) disable iff (!rst_s)
    busy_q |-> ((served & ~pend_q) == '0));
  assert_progress_R3: assert property (@(posedge clk) disable iff (!rst_s)
    (busy_q && (|pend_q)) |-> (|served));
  assert_pend_shrink_R3: assert property (@(posedge clk) disable iff (!rst_s)
    busy_q |=> ((pend_q & ~$past(pend_q)) == '0));
  // R8: the latched group is frozen while in flight
  assert_hold_group_R8: assert property (@(posedge clk) disable iff (!rst_s)
    busy_q |=> (!busy_q || ($stable(addr_q) && $stable(we_q) && $stable(wdata_q))));
  // R9: strobe is a single cycle and only once the group is finished
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_s)
    done_q |=> !done_q);
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_s)
    done_q |-> (!busy_q && (pend_q == '0)));
endmodule

// File: tb/spm_scratchpad_bench.sv
module spm_scratchpad_bench;
  localparam int L  = 16;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int NV = 7;
  // {base[31:20], stride[19:8], rounds[7:0]}
  localparam logic [31:0] VEC [NV] = '{
    {12'd0,    12'd1,  8'd1},
    {12'd256,  12'd16, 8'd16},
    {12'd512,  12'd2,  8'd2},
    {12'd700,  12'd0,  8'd1},
    {12'd800,  12'd4,  8'd4},
    {12'd1000, 12'd17, 8'd1},
    {12'd2000, 12'd8,  8'd8}
  };

  logic clk = 1'b0;
  logic rst_n;
  always #10 clk = ~clk;

  logic [L-1:0]    lane_en, lane_we;
  logic [L*AW-1:0] lane_addr;
  logic [L*DW-1:0] lane_wdata, lane_rdata;
  logic            done;

  spm_scratchpad u_spm_scratchpad (
    .clk(clk), .rst_n(rst_n), .lane_en(lane_en), .lane_we(lane_we),
    .lane_addr(lane_addr), .lane_wdata(lane_wdata),
    .lane_rdata(lane_rdata), .done(done)
  );

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] ref_mem [4096];
  logic [DW-1:0] exp_rd  [L];
  logic [L-1:0]  en_v, we_v;
  logic [AW-1:0] ad_v [L];
  logic [DW-1:0] wd_v [L];

  task automatic check_eq(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive();
    for (int l = 0; l < L; l++) begin
      lane_addr[l*AW +: AW]  = ad_v[l];
      lane_wdata[l*DW +: DW] = wd_v[l];
    end
    lane_en = en_v;
    lane_we = we_v;
  endtask

  // Called just after a falling edge; returns at the falling edge where done is seen.
  task automatic run_group(input int rounds, input string req, input bit inject);
    int lat = 0;
    for (int l = 0; l < L; l++)
      if (en_v[l] && !we_v[l]) exp_rd[l] = ref_mem[ad_v[l]];
    for (int l = 0; l < L; l++)
      if (en_v[l] && we_v[l]) ref_mem[ad_v[l]] = wd_v[l];
    drive();
    while (1) begin
      @(negedge clk);
      lat++;
      if (lat == 1) lane_en = '0;
      if (inject && lat <= 3) begin
        lane_en    = '1;
        lane_we    = '1;
        lane_addr  = {L{12'd100}};
        lane_wdata = {L{32'hDEAD_BEEF}};
      end
      if (inject && lat == 4) lane_en = '0;
      if (done || lat >= 40) break;
    end
    check_eq({req, " latency"}, DW'(lat), DW'(rounds + 1));
    for (int l = 0; l < L; l++)
      check_eq((en_v[l] && !we_v[l]) ? req : "R11", lane_rdata[l*DW +: DW], exp_rd[l]);
  endtask

  task automatic clear_vec();
    en_v = '0;
    we_v = '0;
    for (int l = 0; l < L; l++) begin
      ad_v[l] = '0;
      wd_v[l] = '0;
    end
  endtask

  initial begin
    #3_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    lane_en = '0; lane_we = '0; lane_addr = '0; lane_wdata = '0;
    for (int l = 0; l < L; l++) exp_rd[l] = '0;
    clear_vec();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: reset state
    check_eq("R10 done", DW'(done), 32'd0);
    for (int l = 0; l < L; l++) check_eq("R10 rdata", lane_rdata[l*DW +: DW], '0);

    // table walk: write group then read group for each address pattern
    for (int i = 0; i < NV; i++) begin
      int base, stride, rounds;
      string wtag, rtag;
      base   = int'(VEC[i][31:20]);
      stride = int'(VEC[i][19:8]);
      rounds = int'(VEC[i][7:0]);
      wtag = (stride == 0) ? "R5" : (stride == 17) ? "R1" : (rounds == 1) ? "R2" : "R3";
      rtag = (stride == 0) ? "R4" : "R7";
      en_v = '1;
      we_v = '1;
      for (int l = 0; l < L; l++) begin
        ad_v[l] = AW'(base + stride * l);
        wd_v[l] = {4'hA, 4'(l), ad_v[l], 12'(i)};
      end
      run_group(rounds, wtag, 1'b0);
      we_v = '0;
      run_group(rounds, rtag, 1'b0);
    end

    // R9: strobe drops in the following cycle
    @(negedge clk);
    check_eq("R9 pulse", DW'(done), 32'd0);

    // R6: same-word readers and writers in one round
    clear_vec();
    en_v[0] = 1'b1; we_v[0] = 1'b1; ad_v[0] = 12'd50; wd_v[0] = 32'h1111_0001;
    run_group(1, "R2", 1'b0);
    clear_vec();
    en_v = 16'h00A9; we_v = 16'h0081;
    ad_v[0] = 12'd50; wd_v[0] = 32'h2222_0002;
    ad_v[3] = 12'd50; ad_v[5] = 12'd50;
    ad_v[7] = 12'd50; wd_v[7] = 32'h3333_0003;
    run_group(1, "R6", 1'b0);
    clear_vec();
    en_v[1] = 1'b1; ad_v[1] = 12'd50;
    run_group(1, "R5", 1'b0);

    // R11: disabled lanes carrying write requests change nothing
    clear_vec();
    en_v[2] = 1'b1; ad_v[2] = 12'd50;
    for (int l = 3; l < L; l++) begin
      we_v[l] = 1'b1; ad_v[l] = 12'd50; wd_v[l] = 32'hBAD0_0000 | l;
    end
    run_group(1, "R11", 1'b0);
    clear_vec();
    en_v[4] = 1'b1; ad_v[4] = 12'd50;
    run_group(1, "R11", 1'b0);

    // R8: requests offered while a 16-round group is in flight
    clear_vec();
    en_v[0] = 1'b1; we_v[0] = 1'b1; ad_v[0] = 12'd100; wd_v[0] = 32'h0100_0100;
    run_group(1, "R8", 1'b0);
    en_v = '1; we_v = '1;
    for (int l = 0; l < L; l++) begin
      ad_v[l] = AW'(3000 + 16 * l);
      wd_v[l] = {4'h5, 4'(l), ad_v[l], 12'hC0D};
    end
    run_group(16, "R8", 1'b1);
    we_v = '0;
    run_group(16, "R8", 1'b0);
    // R9: back-to-back acceptance in the done cycle
    clear_vec();
    en_v[9] = 1'b1; ad_v[9] = 12'd100;
    run_group(1, "R9", 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule